// File: doc/BRIEF.md
# Selectable-Path Jitter Attenuator Channel

This block is one channel of a jitter attenuator. It can sit in either the transmit path or the receive path of a line interface. While it is active, bits arriving on the chosen path's input clock-enable go into a small FIFO. They leave the FIFO only on the ticks of a numerically controlled oscillator (NCO). The NCO is steered by the FIFO fill level, so the output clock-enable is a smoothed version of the input one. The path that is not being attenuated, or both paths when the channel is off, passes through a single register stage.

Each line clock is modelled as a one-cycle valid strobe inside a fast system clock domain. The starting mode comes from a three-state strap that is read only while reset is held. The loop-bandwidth default comes from a line-rate code that is also read during reset. After reset, only a one-cycle configuration write changes the mode. That write also clears the sticky FIFO error flags.

Top module: `jitter_atten_chan`

## Requirements
- R1: While `rstN` is low, the mode is taken from the strap. `strapFloat`=1 gives enable=0 and path=0. Otherwise enable=1, and the path equals `strapLevel` (1 = transmit path, 0 = receive path).
- R2: While `rstN` is low, `modeBw` is loaded with 1 when `rateSel`==2 (fastest rate) and with 0 for every other code.
- R3: After reset, changes on `strapLevel`, `strapFloat` and `rateSel` leave `modeEn`, `modePath` and `modeBw` unchanged.
- R4: A cycle with `cfgWr`=1 loads enable from `cfgData[0]`, path from `cfgData[1]` and bandwidth from `cfgData[2]`. The new values appear on `modeEn`, `modePath` and `modeBw` after that clock edge.
- R5: When enable=0, `txOut`/`txOutValid` equal `txData`/`txValid` of the previous cycle, and the same holds for the receive pair. When enable=1, the path that is not selected behaves the same way.
- R6: On the selected path, input bits with valid=1 go into a FIFO of `DEPTH` entries. They come out in arrival order, one per NCO tick. Each output bit appears with its valid=1 on the cycle after the tick. In every other cycle, valid=0 and the data holds its value.
- R7: A write that changes enable or path re-centres the FIFO, and so does every cycle with enable=0. Re-centring leaves `DEPTH/2` zero bits in the FIFO, clears the NCO phase, sets the step to `NOM_STEP`, and clears the attenuated output data and valid.
- R8: A write with no tick while the FIFO already holds `DEPTH` bits sets the sticky `ovfFlag` and re-centres the FIFO.
- R9: A tick while the FIFO is empty sets the sticky `unfFlag` and re-centres the FIFO. No bit is output for that tick.
- R10: A configuration write with `cfgData[3]`=1 clears `ovfFlag`, and one with `cfgData[4]`=1 clears `unfFlag`. A new event in the same cycle wins over the clear.
- R11: Each active, non-re-centring cycle, the next step is `NOM_STEP + (((fill - DEPTH/2) << ERR_GAIN_LOG2) >>> s)`. The shift `s` is `SHIFT_WIDE` when bandwidth=1 and `SHIFT_NARROW` when bandwidth=0. A tick is the carry out of the `ACC_W`-bit phase accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset; strap and rate are read while low |
| strapLevel | input | 1 | Strap level when driven: 1 transmit path, 0 receive path |
| strapFloat | input | 1 | Strap left floating: attenuator off |
| rateSel | input | 2 | Line-rate code; 2 is the fastest rate |
| cfgWr | input | 1 | Configuration write strobe |
| cfgData | input | 5 | {clear-underflow, clear-overflow, bandwidth, path, enable} |
| txData | input | 1 | Transmit input bit |
| txValid | input | 1 | Transmit input clock-enable |
| rxData | input | 1 | Recovered receive bit |
| rxValid | input | 1 | Recovered receive clock-enable |
| txOut | output | 1 | Transmit output bit |
| txOutValid | output | 1 | Transmit output clock-enable |
| rxOut | output | 1 | Receive output bit |
| rxOutValid | output | 1 | Receive output clock-enable |
| modeEn | output | 1 | Current enable bit |
| modePath | output | 1 | Current path bit |
| modeBw | output | 1 | Current bandwidth bit |
| ovfFlag | output | 1 | Sticky FIFO overflow |
| unfFlag | output | 1 | Sticky FIFO underflow |

## Verification
The bench builds the channel with `DEPTH`=8, a 16-bit accumulator, a nominal step of 0x2000 (one tick per eight cycles) and shifts of 2 and 4. A four-entry half-fill lets steady input on every cycle reach overflow within a few cycles, and sparse input reach underflow. Both flags are therefore hit many times in a short run. The small loop gain keeps the step positive over the whole fill range, so the bench can also check the steady-tracking case, with input every eighth cycle, against its model cycle by cycle.

// File: rtl/jac_pkg.sv
package jac_pkg;
  localparam int CFG_W       = 5;
  localparam int CFG_EN_BIT  = 0;
  localparam int CFG_PATH_BIT = 1;
  localparam int CFG_BW_BIT  = 2;
  localparam int CFG_CLR_OVF = 3;
  localparam int CFG_CLR_UNF = 4;
  localparam logic [1:0] RATE_FAST = 2'd2;

  typedef struct packed {
    logic enable;
    logic pathTx;
    logic bwWide;
    logic recenter;
  } jaCtrlS;
endpackage

// File: rtl/jac_ctrl.sv
module jac_ctrl
  import jac_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             strapLevel,
  input  logic             strapFloat,
  input  logic [1:0]       rateSel,
  input  logic             cfgWr,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             ovfEvt,
  input  logic             unfEvt,
  output jaCtrlS           ctrlS,
  output logic             modeEn,
  output logic             modePath,
  output logic             modeBw,
  output logic             ovfFlag,
  output logic             unfFlag
);
  logic enReg, pathReg, bwReg, ovfReg, unfReg;
  logic modeChange;

  assign modeChange = cfgWr && ((cfgData[CFG_EN_BIT] != enReg) ||
                                (cfgData[CFG_PATH_BIT] != pathReg));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg   <= !strapFloat;
      pathReg <= !strapFloat && strapLevel;
      bwReg   <= (rateSel == RATE_FAST);
      ovfReg  <= 1'b0;
      unfReg  <= 1'b0;
    end else begin
      if (cfgWr) begin
        enReg   <= cfgData[CFG_EN_BIT];
        pathReg <= cfgData[CFG_PATH_BIT];
        bwReg   <= cfgData[CFG_BW_BIT];
      end
      ovfReg <= ovfEvt || (ovfReg && !(cfgWr && cfgData[CFG_CLR_OVF]));
      unfReg <= unfEvt || (unfReg && !(cfgWr && cfgData[CFG_CLR_UNF]));
    end
  end

  always_comb begin
    ctrlS.enable   = enReg;
    ctrlS.pathTx   = pathReg;
    ctrlS.bwWide   = bwReg;
    ctrlS.recenter = modeChange;
  end

  assign modeEn   = enReg;
  assign modePath = pathReg;
  assign modeBw   = bwReg;
  assign ovfFlag  = ovfReg;
  assign unfFlag  = unfReg;
endmodule

// File: rtl/jac_datapath.sv
module jac_datapath
  import jac_pkg::*;
#(
  parameter int DEPTH         = 32,
  parameter int ACC_W         = 16,
  parameter logic [ACC_W-1:0] NOM_STEP = 16'h2000,
  parameter int ERR_GAIN_LOG2 = 8,
  parameter int SHIFT_WIDE    = 2,
  parameter int SHIFT_NARROW  = 4,
  localparam int CNT_W        = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  jaCtrlS           ctrlS,
  input  logic             txData,
  input  logic             txValid,
  input  logic             rxData,
  input  logic             rxValid,
  output logic             txOut,
  output logic             txOutValid,
  output logic             rxOut,
  output logic             rxOutValid,
  output logic             ovfEvt,
  output logic             unfEvt,
  output logic [CNT_W-1:0] fillLevel
);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int HALF   = DEPTH / 2;
  localparam int CALC_W = ACC_W + 2;
  localparam logic signed [CALC_W-1:0] HALF_S = CALC_W'(HALF);
  localparam logic signed [CALC_W-1:0] NOM_S  = {2'b00, NOM_STEP};

  logic [DEPTH-1:0] mem;
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] count;
  logic [ACC_W-1:0] phase, step, stepNext;
  logic [ACC_W:0]   phaseSum;
  logic tick, inData, inValid, hold, reCentre;
  logic attData, attValid;
  logic bypTxD, bypTxV, bypRxD, bypRxV;
  logic signed [CALC_W-1:0] errS, corrS;

  assign inData   = ctrlS.pathTx ? txData  : rxData;
  assign inValid  = ctrlS.pathTx ? txValid : rxValid;
  assign hold     = ctrlS.recenter || !ctrlS.enable;
  assign phaseSum = {1'b0, phase} + {1'b0, step};
  assign tick     = phaseSum[ACC_W];

  assign unfEvt   = !hold && tick && (count == '0);
  assign ovfEvt   = !hold && inValid && !tick && (count == CNT_W'(DEPTH));
  assign reCentre = hold || unfEvt || ovfEvt;

  // loop filter: scaled fill error around half-full
  assign errS  = $signed({{(CALC_W-CNT_W){1'b0}}, count}) - HALF_S;
  assign corrS = ctrlS.bwWide ? ((errS <<< ERR_GAIN_LOG2) >>> SHIFT_WIDE)
                              : ((errS <<< ERR_GAIN_LOG2) >>> SHIFT_NARROW);
  assign stepNext = ACC_W'(NOM_S + corrS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bypTxD <= 1'b0; bypTxV <= 1'b0;
      bypRxD <= 1'b0; bypRxV <= 1'b0;
    end else begin
      bypTxD <= txData; bypTxV <= txValid;
      bypRxD <= rxData; bypRxV <= rxValid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || reCentre) begin
      mem      <= '0;
      rdPtr    <= '0;
      wrPtr    <= PTR_W'(HALF);
      count    <= CNT_W'(HALF);
      phase    <= '0;
      step     <= NOM_STEP;
      attData  <= 1'b0;
      attValid <= 1'b0;
    end else begin
      phase    <= phaseSum[ACC_W-1:0];
      step     <= stepNext;
      attValid <= tick;
      if (tick) begin
        attData <= mem[rdPtr];
        rdPtr   <= rdPtr + 1'b1;
      end
      if (inValid) begin
        mem[wrPtr] <= inData;
        wrPtr      <= wrPtr + 1'b1;
      end
      case ({inValid, tick})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign fillLevel  = count;
  assign txOut      = (ctrlS.enable &&  ctrlS.pathTx) ? attData  : bypTxD;
  assign txOutValid = (ctrlS.enable &&  ctrlS.pathTx) ? attValid : bypTxV;
  assign rxOut      = (ctrlS.enable && !ctrlS.pathTx) ? attData  : bypRxD;
  assign rxOutValid = (ctrlS.enable && !ctrlS.pathTx) ? attValid : bypRxV;
endmodule

// File: rtl/jitter_atten_chan.sv
module jitter_atten_chan
  import jac_pkg::*;
#(
  parameter int DEPTH         = 32,
  parameter int ACC_W         = 16,
  parameter logic [ACC_W-1:0] NOM_STEP = 16'h2000,
  parameter int ERR_GAIN_LOG2 = 8,
  parameter int SHIFT_WIDE    = 2,
  parameter int SHIFT_NARROW  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             strapLevel,
  input  logic             strapFloat,
  input  logic [1:0]       rateSel,
  input  logic             cfgWr,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             txData,
  input  logic             txValid,
  input  logic             rxData,
  input  logic             rxValid,
  output logic             txOut,
  output logic             txOutValid,
  output logic             rxOut,
  output logic             rxOutValid,
  output logic             modeEn,
  output logic             modePath,
  output logic             modeBw,
  output logic             ovfFlag,
  output logic             unfFlag
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  jaCtrlS ctrlS;
  logic ovfEvt, unfEvt;
  logic [CNT_W-1:0] fillLevel;

  jac_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .strapLevel(strapLevel), .strapFloat(strapFloat),
    .rateSel(rateSel), .cfgWr(cfgWr), .cfgData(cfgData),
    .ovfEvt(ovfEvt), .unfEvt(unfEvt), .ctrlS(ctrlS),
    .modeEn(modeEn), .modePath(modePath), .modeBw(modeBw),
    .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

  jac_datapath #(
    .DEPTH(DEPTH), .ACC_W(ACC_W), .NOM_STEP(NOM_STEP),
    .ERR_GAIN_LOG2(ERR_GAIN_LOG2), .SHIFT_WIDE(SHIFT_WIDE),
    .SHIFT_NARROW(SHIFT_NARROW)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctrlS(ctrlS),
    .txData(txData), .txValid(txValid), .rxData(rxData), .rxValid(rxValid),
    .txOut(txOut), .txOutValid(txOutValid), .rxOut(rxOut), .rxOutValid(rxOutValid),
    .ovfEvt(ovfEvt), .unfEvt(unfEvt), .fillLevel(fillLevel)
  );
endmodule

// File: rtl/jac_checker.sv
module jac_checker #(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWr,
  input logic [4:0]       cfgData,
  input logic             txData,
  input logic             txValid,
  input logic             txOut,
  input logic             txOutValid,
  input logic             modeEn,
  input logic             modePath,
  input logic             modeBw,
  input logic             ovfFlag,
  input logic             unfFlag,
  input logic             ovfEvt,
  input logic             unfEvt,
  input logic             recenter,
  input logic [CNT_W-1:0] fillLevel
);
  a_r3_mode_holds: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWr |=> ($stable(modeEn) && $stable(modePath) && $stable(modeBw)));

  a_r4_write_loads: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |=> (modeEn == $past(cfgData[0]) && modePath == $past(cfgData[1]) &&
               modeBw == $past(cfgData[2])));

  a_r5_bypass_copy: assert property (@(posedge clk) disable iff (!rstN)
    (!modeEn && !cfgWr) |=> (txOut == $past(txData) && txOutValid == $past(txValid)));

  a_r6_fill_bound: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= CNT_W'(DEPTH));

  a_r7_recentre_half: assert property (@(posedge clk) disable iff (!rstN)
    (recenter || !modeEn) |=> fillLevel == CNT_W'(DEPTH / 2));

  a_r8_overflow_sets: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvt |=> ovfFlag);

  a_r9_underflow_sets: assert property (@(posedge clk) disable iff (!rstN)
    unfEvt |=> unfFlag);

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(cfgWr && cfgData[3])) |=> ovfFlag);

  a_r10_unf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (unfFlag && !(cfgWr && cfgData[4])) |=> unfFlag);
endmodule

bind jitter_atten_chan jac_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgData(cfgData),
  .txData(txData), .txValid(txValid), .txOut(txOut), .txOutValid(txOutValid),
  .modeEn(modeEn), .modePath(modePath), .modeBw(modeBw),
  .ovfFlag(ovfFlag), .unfFlag(unfFlag), .ovfEvt(ovfEvt), .unfEvt(unfEvt),
  .recenter(ctrlS.recenter), .fillLevel(fillLevel)
);

// File: tb/jitter_atten_chan_tb_top.sv
module jitter_atten_chan_tb_top;
  localparam int DEPTH = 8;
  localparam int HALF  = DEPTH / 2;
  localparam int ACC_W = 16;
  localparam int NOM   = 'h2000;
  localparam int GAIN  = 8;
  localparam int SW    = 2;
  localparam int SN    = 4;
  localparam int WRAP  = 1 << ACC_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strapLevel = 1'b0, strapFloat = 1'b1;
  logic [1:0] rateSel = 2'd0;
  logic cfgWr = 1'b0;
  logic [4:0] cfgData = '0;
  logic txData = 1'b0, txValid = 1'b0, rxData = 1'b0, rxValid = 1'b0;
  logic txOut, txOutValid, rxOut, rxOutValid, modeEn, modePath, modeBw, ovfFlag, unfFlag;

  int checks = 0;
  int errors = 0;
  string curTag = "R1";

  always #10 clk = ~clk;

  jitter_atten_chan #(
    .DEPTH(DEPTH), .ACC_W(ACC_W), .NOM_STEP(16'h2000),
    .ERR_GAIN_LOG2(GAIN), .SHIFT_WIDE(SW), .SHIFT_NARROW(SN)
  ) dut_i (
    .clk(clk), .rstN(rstN), .strapLevel(strapLevel), .strapFloat(strapFloat),
    .rateSel(rateSel), .cfgWr(cfgWr), .cfgData(cfgData),
    .txData(txData), .txValid(txValid), .rxData(rxData), .rxValid(rxValid),
    .txOut(txOut), .txOutValid(txOutValid), .rxOut(rxOut), .rxOutValid(rxOutValid),
    .modeEn(modeEn), .modePath(modePath), .modeBw(modeBw),
    .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

  // behavioural reference state
  bit mEn, mPath, mBw, mOvf, mUnf;
  bit mq[$];
  int mPhase, mStep;
  bit mAttD, mAttV, mByTxD, mByTxV, mByRxD, mByRxV;

  task automatic mCentre();
    mq.delete();
    for (int i = 0; i < HALF; i++) mq.push_back(1'b0);
    mPhase = 0; mStep = NOM; mAttD = 0; mAttV = 0;
  endtask

  task automatic mReset();
    mEn = !strapFloat; mPath = !strapFloat && strapLevel;
    mBw = (rateSel == 2'd2); mOvf = 0; mUnf = 0;
    mByTxD = 0; mByTxV = 0; mByRxD = 0; mByRxV = 0;
    mCentre();
  endtask

  task automatic mAdvance();
    bit hold, inV, inD, tk, ovfE, unfE;
    int sum, e, sh;
    hold = !mEn || (cfgWr && (cfgData[0] != mEn || cfgData[1] != mPath));
    inV = mPath ? txValid : rxValid;
    inD = mPath ? txData : rxData;
    sum = mPhase + mStep;
    tk = (sum >= WRAP);
    ovfE = 0; unfE = 0;
    mByTxD = txData; mByTxV = txValid; mByRxD = rxData; mByRxV = rxValid;
    if (hold) mCentre();
    else begin
      unfE = tk && (mq.size() == 0);
      ovfE = inV && !tk && (mq.size() == DEPTH);
      if (unfE || ovfE) mCentre();
      else begin
        e = mq.size() - HALF;
        sh = mBw ? SW : SN;
        mStep = NOM + ((e * (1 << GAIN)) >>> sh);
        mPhase = sum % WRAP;
        mAttV = tk;
        if (tk) mAttD = mq.pop_front();
        if (inV) mq.push_back(inD);
      end
    end
    mOvf = ovfE || (mOvf && !(cfgWr && cfgData[3]));
    mUnf = unfE || (mUnf && !(cfgWr && cfgData[4]));
    if (cfgWr) begin mEn = cfgData[0]; mPath = cfgData[1]; mBw = cfgData[2]; end
  endtask

  task automatic chk(string what, string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("txOut",      curTag, txOut,      (mEn && mPath)  ? mAttD : mByTxD);
    chk("txOutValid", curTag, txOutValid, (mEn && mPath)  ? mAttV : mByTxV);
    chk("rxOut",      curTag, rxOut,      (mEn && !mPath) ? mAttD : mByRxD);
    chk("rxOutValid", curTag, rxOutValid, (mEn && !mPath) ? mAttV : mByRxV);
    chk("modeEn",   curTag, modeEn,   mEn);
    chk("modePath", curTag, modePath, mPath);
    chk("modeBw",   curTag, modeBw,   mBw);
    chk("ovfFlag",  curTag, ovfFlag,  mOvf);
    chk("unfFlag",  curTag, unfFlag,  mUnf);
  endtask

  // inputs are set at a falling edge before this is called
  task automatic cycle();
    if (!rstN) mReset(); else mAdvance();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic doReset(bit lvl, bit flt, logic [1:0] rate);
    rstN = 0; strapLevel = lvl; strapFloat = flt; rateSel = rate;
    cfgWr = 0; txValid = 0; rxValid = 0;
    cycle(); cycle();
    rstN = 1;
  endtask

  task automatic cfgWrite(logic [4:0] d);
    cfgWr = 1; cfgData = d; txValid = 0; rxValid = 0;
    cycle();
    cfgWr = 0;
  endtask

  task automatic traffic(int n, int txEvery, int rxEvery);
    for (int i = 0; i < n; i++) begin
      txValid = (i % txEvery) == 0;
      rxValid = (i % rxEvery) == 0;
      txData = 1'($urandom);
      rxData = 1'($urandom);
      cycle();
    end
    txValid = 0; rxValid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // floating strap, slow rate
    curTag = "R1"; doReset(1'b0, 1'b1, 2'd0);
    chk("modeEn after float strap", "R1", modeEn, 1'b0);
    chk("modeBw slow rate", "R2", modeBw, 1'b0);
    curTag = "R5"; traffic(40, 1, 2);
    // strap and rate moves after reset must be ignored
    curTag = "R3";
    strapFloat = 0; strapLevel = 1; rateSel = 2'd2;
    traffic(10, 3, 1);
    chk("modeEn after strap change", "R3", modeEn, 1'b0);
    chk("modeBw after rate change", "R3", modeBw, 1'b0);
    // driven-high strap, fastest rate
    curTag = "R1"; doReset(1'b1, 1'b0, 2'd2);
    chk("modeEn high strap", "R1", modeEn, 1'b1);
    chk("modePath high strap", "R1", modePath, 1'b1);
    chk("modeBw fast rate", "R2", modeBw, 1'b1);
    // input faster than NCO: overflow on transmit path
    curTag = "R8"; traffic(200, 1, 2);
    chk("ovfFlag after flood", "R8", ovfFlag, 1'b1);
    curTag = "R10"; cfgWrite(5'b01111);
    chk("ovfFlag cleared", "R10", ovfFlag, 1'b0);
    chk("modeEn kept", "R4", modeEn, 1'b1);
    // balanced traffic: loop tracking
    curTag = "R11"; traffic(400, 8, 3);
    curTag = "R6";  traffic(300, 7, 5);
    // move to receive path, narrow bandwidth
    curTag = "R7"; cfgWrite(5'b10001);
    chk("modePath receive", "R4", modePath, 1'b0);
    chk("modeBw narrow", "R4", modeBw, 1'b0);
    chk("rxOutValid after recentre", "R7", rxOutValid, 1'b0);
    // sparse receive input: underflow
    curTag = "R9"; traffic(300, 2, 20);
    chk("unfFlag after starve", "R9", unfFlag, 1'b1);
    curTag = "R10"; cfgWrite(5'b10001);
    chk("unfFlag cleared", "R10", unfFlag, 1'b0);
    curTag = "R11"; traffic(300, 1, 8);
    // disable: both paths bypass
    curTag = "R5"; cfgWrite(5'b00000);
    chk("modeEn off", "R5", modeEn, 1'b0);
    traffic(60, 1, 1);
    // driven-low strap, middle rate
    curTag = "R1"; doReset(1'b0, 1'b0, 2'd1);
    chk("modeEn low strap", "R1", modeEn, 1'b1);
    chk("modePath low strap", "R1", modePath, 1'b0);
    chk("modeBw mid rate", "R2", modeBw, 1'b0);
    curTag = "R6"; traffic(300, 1, 8);
    curTag = "R4"; cfgWrite(5'b00111);
    curTag = "R6"; traffic(200, 9, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule